// File: doc/BRIEF.md
# DRAM Refresh Timer Controller

This block paces refresh for a simple DRAM bus controller. A free-running up-counter is compared every clock against a programmable constant. When the two are equal, the counter restarts from zero on the next clock, so matches recur every constant+1 cycles. Each match sets a compare-match flag.

With refresh disabled, the flag serves as a software timer flag. It can drive an interrupt, and software clears it with a read-then-write-0 handshake. With refresh enabled, each match posts a CAS-before-RAS refresh request to the bus arbiter. Once the bus is granted, the block drives the CAS and RAS strobes through the refresh cycle. The CAS-to-RAS gap is programmable, and starting the cycle clears the flag in hardware. While refresh is enabled, the interrupt enable is held at zero.

Software reaches three registers through a small register port. It selects a register on `reg_sel`, writes with a one-cycle `reg_wr` strobe, and reads through `reg_rdata`. `reg_rd` marks a read of the control register, which arms the flag-clear handshake.

Top module: `drf_refresh_timer`

## Requirements
- R1: The counter (reg_sel 1) advances by one each clock. In the clock after it equals the constant (reg_sel 2), it becomes 0, giving a period of constant+1. Both registers are written with reg_wr and read on reg_rdata, and a counter write takes priority over counting.
- R2: The flag (control bit 0) becomes 1 on the clock edge that ends a cycle in which counter equals constant. It is never set otherwise.
- R3: While refresh is disabled (control bit 2 = 0), the flag is cleared only by a control write with bit 0 = 0 that follows a control read (reg_rd) that returned the flag as 1. A write of 0 with no such read, or a write of 1, leaves the flag unchanged.
- R4: While refresh is enabled, the flag is cleared on the edge at which a refresh cycle starts.
- R5: cmi_irq is 1 exactly when the flag is 1 and the interrupt enable (control bit 1) is 1.
- R6: While refresh is enabled, the interrupt enable reads 0 and writes to it are ignored.
- R7: With refresh enabled, a match raises rfsh_req, which stays high until the bus is granted. With refresh disabled, rfsh_req stays 0.
- R8: A refresh cycle starts when rfsh_req and bus_grant are both high while the block is idle. From the next cycle, cas_n is low for 1+W cycles, where W is control bits 4:3 (00=0, 01=1, 10=2, 11=3 waits). Both strobes are then low for 2 cycles, then both high for 1 precharge cycle. rfsh_busy is high from the first CAS cycle through the precharge cycle.
- R9: Control bit 5 is a spare bit that reads back the last value written to it.
- R10: While rst_n is low and after reset, all registers are 0, both strobes are high, and rfsh_req, rfsh_busy and cmi_irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 control, 1 counter, 2 constant |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read marker, used for control-register reads |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register, zero-extended |
| cmi_irq | output | 1 | Compare-match interrupt request |
| bus_grant | input | 1 | Bus granted to the refresh cycle |
| rfsh_req | output | 1 | Refresh request to the bus arbiter |
| rfsh_busy | output | 1 | Refresh cycle in progress |
| cas_n | output | 1 | Column strobe, active low |
| ras_n | output | 1 | Row strobe, active low |

## Verification
A register write lands on the clock edge that samples `reg_wr`, and its effect is checked at the following falling edge. The flag rises on the edge after the cycle in which the counter reads equal to the constant, and that same edge returns the counter to zero. The bench loads the counter a known distance from the constant and checks the flag cycle by cycle around that edge. The interrupt is a combinational function of the flag and the enable, so it is checked in the same half-cycle as they are. For refresh, the first strobe cycle follows the edge that saw the grant, and the bench walks the whole 1+W, 2 and 1 cycle pattern for each W, one falling edge at a time.

// File: rtl/drf_pkg.sv
package drf_pkg;
  localparam int unsigned CTRL_W = 6;
  localparam int unsigned BIT_FLAG = 0;
  localparam int unsigned BIT_IEN = 1;
  localparam int unsigned BIT_RFEN = 2;
  localparam int unsigned BIT_WAIT = 3;
  localparam int unsigned BIT_SPARE = 5;
  localparam int unsigned RAS_CYCLES = 2;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CNT = 2'd1;
  localparam logic [1:0] SEL_CONST = 2'd2;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_CAS, SEQ_RAS, SEQ_PRE} seq_state_e;

  // Cycles with CAS low before RAS falls: one base cycle plus the waits.
  function automatic logic [2:0] cas_lead_cycles(input logic [1:0] wait_sel);
    return 3'(wait_sel) + 3'd1;
  endfunction

  // Total busy cycles of one refresh: CAS lead, RAS window, precharge.
  function automatic logic [3:0] busy_cycles(input logic [1:0] wait_sel);
    return 4'(cas_lead_cycles(wait_sel)) + 4'(RAS_CYCLES) + 4'd1;
  endfunction
endpackage

// File: rtl/drf_counter.sv
module drf_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic             const_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] const_q,
  output logic             match_evt
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic hit);
    return hit ? '0 : cur + CNT_W'(1);
  endfunction

  assign match_evt = (cnt_q == const_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      const_q <= '0;
    end else begin
      if (cnt_wr) cnt_q <= wdata;
      else        cnt_q <= next_count(cnt_q, match_evt);
      if (const_wr) const_q <= wdata;
    end
  end
endmodule

// File: rtl/drf_ctrl_regs.sv
module drf_ctrl_regs
  import drf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_rd,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              match_evt,
  input  logic              seq_start,
  output logic              flag_q,
  output logic              irq_en_q,
  output logic              rfsh_en_q,
  output logic [1:0]        wait_sel_q,
  output logic [CTRL_W-1:0] ctrl_word
);
  logic spare_q;
  logic armed_q;
  logic rfsh_en_nx;
  logic sw_clear;
  logic hw_clear;

  assign rfsh_en_nx = ctrl_wr ? wdata[BIT_RFEN] : rfsh_en_q;
  assign sw_clear = ctrl_wr && !wdata[BIT_FLAG] && armed_q && !rfsh_en_q;
  assign hw_clear = seq_start;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_FLAG] = flag_q;
    ctrl_word[BIT_IEN] = irq_en_q;
    ctrl_word[BIT_RFEN] = rfsh_en_q;
    ctrl_word[BIT_WAIT +: 2] = wait_sel_q;
    ctrl_word[BIT_SPARE] = spare_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q     <= 1'b0;
      irq_en_q   <= 1'b0;
      rfsh_en_q  <= 1'b0;
      wait_sel_q <= 2'd0;
      spare_q    <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      if (match_evt)                 flag_q <= 1'b1;
      else if (sw_clear || hw_clear) flag_q <= 1'b0;

      if (ctrl_wr)                   armed_q <= 1'b0;
      else if (ctrl_rd && flag_q)    armed_q <= 1'b1;

      rfsh_en_q <= rfsh_en_nx;
      if (rfsh_en_nx)   irq_en_q <= 1'b0;
      else if (ctrl_wr) irq_en_q <= wdata[BIT_IEN];

      if (ctrl_wr) begin
        wait_sel_q <= wdata[BIT_WAIT +: 2];
        spare_q    <= wdata[BIT_SPARE];
      end
    end
  end
endmodule

// File: rtl/drf_strobe_seq.sv
module drf_strobe_seq
  import drf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_set,
  input  logic       bus_grant,
  input  logic [1:0] wait_sel,
  output logic       rfsh_req,
  output logic       busy,
  output logic       cas_n,
  output logic       ras_n,
  output logic       seq_start
);
  seq_state_e state_q;
  logic [2:0] left_q;
  logic       pending_q;

  assign rfsh_req  = pending_q;
  assign seq_start = pending_q && bus_grant && (state_q == SEQ_IDLE);
  assign busy      = (state_q != SEQ_IDLE);
  assign cas_n     = !((state_q == SEQ_CAS) || (state_q == SEQ_RAS));
  assign ras_n     = !(state_q == SEQ_RAS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      left_q    <= 3'd0;
      pending_q <= 1'b0;
    end else begin
      pending_q <= req_set || (pending_q && !seq_start);
      unique case (state_q)
        SEQ_IDLE: if (seq_start) begin
          state_q <= SEQ_CAS;
          left_q  <= cas_lead_cycles(wait_sel) - 3'd1;
        end
        SEQ_CAS: if (left_q == 3'd0) begin
          state_q <= SEQ_RAS;
          left_q  <= 3'(RAS_CYCLES - 1);
        end else left_q <= left_q - 3'd1;
        SEQ_RAS: if (left_q == 3'd0) state_q <= SEQ_PRE;
                 else left_q <= left_q - 3'd1;
        SEQ_PRE: state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/drf_refresh_timer.sv
module drf_refresh_timer
  import drf_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cmi_irq,
  input  logic              bus_grant,
  output logic              rfsh_req,
  output logic              rfsh_busy,
  output logic              cas_n,
  output logic              ras_n
);
  logic              ctrl_wr, ctrl_rd, cnt_wr, const_wr;
  logic              match_evt, seq_start, refresh_hit;
  logic [CNT_W-1:0]  cnt_q, const_q;
  logic              flag_q, irq_en_q, rfsh_en_q;
  logic [1:0]        wait_sel_q;
  logic [CTRL_W-1:0] ctrl_word;

  assign ctrl_wr     = reg_wr && (reg_sel == SEL_CTRL);
  assign ctrl_rd     = reg_rd && (reg_sel == SEL_CTRL);
  assign cnt_wr      = reg_wr && (reg_sel == SEL_CNT);
  assign const_wr    = reg_wr && (reg_sel == SEL_CONST);
  assign refresh_hit = match_evt && rfsh_en_q;
  assign cmi_irq     = flag_q && irq_en_q;

  drf_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .const_wr(const_wr),
    .wdata(reg_wdata[CNT_W-1:0]), .cnt_q(cnt_q), .const_q(const_q),
    .match_evt(match_evt)
  );

  drf_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
    .wdata(reg_wdata[CTRL_W-1:0]), .match_evt(match_evt), .seq_start(seq_start),
    .flag_q(flag_q), .irq_en_q(irq_en_q), .rfsh_en_q(rfsh_en_q),
    .wait_sel_q(wait_sel_q), .ctrl_word(ctrl_word)
  );

  drf_strobe_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_set(refresh_hit), .bus_grant(bus_grant),
    .wait_sel(wait_sel_q), .rfsh_req(rfsh_req), .busy(rfsh_busy),
    .cas_n(cas_n), .ras_n(ras_n), .seq_start(seq_start)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl_word;
      SEL_CNT:   reg_rdata[CNT_W-1:0]  = cnt_q;
      SEL_CONST: reg_rdata[CNT_W-1:0]  = const_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/drf_refresh_timer_chk.sv
module drf_refresh_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             match_evt,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flag_q,
  input logic             irq_en_q,
  input logic             rfsh_en_q,
  input logic             cmi_irq,
  input logic             seq_start,
  input logic             rfsh_busy,
  input logic             rfsh_req,
  input logic             cas_n,
  input logic             ras_n
);
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !cnt_wr) |=> (cnt_q == '0));

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_q);

  assert_flag_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(match_evt));

  assert_hw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && !match_evt) |=> !flag_q);

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmi_irq |-> (flag_q && irq_en_q));

  assert_ien_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_en_q |-> !irq_en_q);

  assert_no_req_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_req) |-> $past(rfsh_en_q));

  assert_ras_in_cas_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  assert_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> rfsh_busy);

  assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> (rfsh_busy && !cas_n && ras_n));
endmodule

bind drf_refresh_timer drf_refresh_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .cnt_wr(cnt_wr),
  .cnt_q(cnt_q), .flag_q(flag_q), .irq_en_q(irq_en_q), .rfsh_en_q(rfsh_en_q),
  .cmi_irq(cmi_irq), .seq_start(seq_start), .rfsh_busy(rfsh_busy),
  .rfsh_req(rfsh_req), .cas_n(cas_n), .ras_n(ras_n)
);

// File: tb/drf_refresh_timer_bench.sv
module drf_refresh_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cmi_irq, bus_grant = 1'b0, rfsh_req, rfsh_busy, cas_n, ras_n;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  drf_refresh_timer u_drf_refresh_timer (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmi_irq(cmi_irq),
    .bus_grant(bus_grant), .rfsh_req(rfsh_req), .rfsh_busy(rfsh_busy),
    .cas_n(cas_n), .ras_n(ras_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a write at a falling edge; returns at the falling edge after it lands.
  task automatic wr(input logic [1:0] sel, input int data);
    @(negedge clk);
    reg_sel = sel; reg_wdata = 16'(data); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd0;
  endtask

  task automatic rd_ctrl(output int val);
    @(negedge clk);
    reg_sel = 2'd0; reg_rd = 1'b1;
    val = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic int ctrl_now();
    return int'(reg_rdata[5:0]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    // R10: values while reset is held
    repeat (2) @(negedge clk);
    reg_sel = 2'd0; #1 check("R10 ctrl", int'(reg_rdata), 0);
    reg_sel = 2'd2; #1 check("R10 const", int'(reg_rdata), 0);
    check("R10 strobes", {cas_n, ras_n}, 3);
    check("R10 req/busy/irq", {rfsh_req, rfsh_busy, cmi_irq}, 0);
    reg_sel = 2'd0;
    rst_n = 1'b1;

    // R9: spare bit readback
    wr(2'd0, 32'h20);
    check("R9 spare", (ctrl_now() >> 5) & 1, 1);
    wr(2'd0, 0);
    check("R9 spare cleared", (ctrl_now() >> 5) & 1, 0);

    // R1: period sweep over constants 0..7
    for (int k = 0; k < 8; k++) begin
      wr(2'd2, k);
      wr(2'd1, 0);
      reg_sel = 2'd1;
      for (int n = 0; n < 2 * (k + 1) + 1; n++) begin
        check("R1 count", int'(reg_rdata), n % (k + 1));
        @(negedge clk);
      end
      reg_sel = 2'd0;
    end

    // R3: clearing handshake, refresh disabled
    wr(2'd2, 200);
    wr(2'd1, 0);
    rd_ctrl(v);
    wr(2'd0, 0);
    check("R3 cleared after read", ctrl_now() & 1, 0);
    wr(2'd0, 1);
    check("R3 write 1 ignored", ctrl_now() & 1, 0);
    // R2: load 198, match at 200 two edges later, flag one edge after that
    wr(2'd1, 198);
    check("R2 flag before match", ctrl_now() & 1, 0);
    @(negedge clk);
    check("R2 flag before match", ctrl_now() & 1, 0);
    @(negedge clk);
    reg_sel = 2'd1; #1 check("R1 at constant", int'(reg_rdata), 200);
    reg_sel = 2'd0; #1 check("R2 flag on match cycle", ctrl_now() & 1, 0);
    @(negedge clk);
    check("R2 flag set", ctrl_now() & 1, 1);
    reg_sel = 2'd1; #1 check("R1 wrap", int'(reg_rdata), 0);
    reg_sel = 2'd0;
    check("R7 no request when disabled", rfsh_req, 0);
    wr(2'd0, 0);
    check("R3 write 0 without read", ctrl_now() & 1, 1);
    rd_ctrl(v);
    check("R3 read value", v & 1, 1);
    wr(2'd0, 0);
    check("R3 read then write 0", ctrl_now() & 1, 0);

    // R5: interrupt gating
    wr(2'd0, 32'h02);
    check("R5 irq off with flag 0", cmi_irq, 0);
    wr(2'd1, 199);
    repeat (2) @(negedge clk);
    check("R5 irq on", cmi_irq, 1);
    wr(2'd0, 32'h01);
    check("R5 irq off with enable 0", cmi_irq, 0);
    check("R3 flag kept", ctrl_now() & 1, 1);

    // R4, R6, R7, R8: refresh cycles for every wait setting
    wr(2'd2, 20);
    for (int w = 0; w < 4; w++) begin
      wr(2'd0, 32'h06 | (w << 3));
      check("R6 enable reads 0", (ctrl_now() >> 1) & 1, 0);
      check("R6 irq off", cmi_irq, 0);
      for (int t = 0; t < 60 && !rfsh_req; t++) @(negedge clk);
      check("R7 request raised", rfsh_req, 1);
      check("R2 flag with request", ctrl_now() & 1, 1);
      check("R8 idle before grant", rfsh_busy, 0);
      bus_grant = 1'b1;
      @(negedge clk);
      bus_grant = 1'b0;
      check("R4 flag cleared by refresh", ctrl_now() & 1, 0);
      check("R7 request dropped", rfsh_req, 0);
      for (int i = 1; i <= w + 5; i++) begin
        check("R8 cas_n", cas_n, (i <= w + 3) ? 0 : 1);
        check("R8 ras_n", ras_n, (i >= w + 2 && i <= w + 3) ? 0 : 1);
        check("R8 busy", rfsh_busy, (i <= w + 4) ? 1 : 0);
        @(negedge clk);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule